// File: doc/BRIEF.md
# Proximity Threshold Interrupt Filter

This block decides when a proximity measurement should interrupt the host. Each new 16-bit result arrives with a one-cycle valid strobe. The block compares it against a programmable low bound and high bound. A consecutive-count persistence filter then decides whether the result raises the interrupt.

Once raised, the interrupt status latches. It holds until a clear pulse arrives. The status is always computed. An enable bit only gates whether it reaches the active-low level output pin.

The same clear pulse also drops a sticky saturation flag, which the integrator front end sets with a one-cycle event. A one-cycle interrupt-generated pulse goes to the measurement sequencer, which uses it to decide whether to sleep after an interrupt.

Top module: `prox_irq_filter`

## Requirements
- R1: With `thr_lo_i <= thr_hi_i`, a result is out of range when it is strictly below `thr_lo_i` or strictly above `thr_hi_i`. A result equal to either bound is in range.
- R2: With `thr_lo_i > thr_hi_i`, the high bound is ignored. A result is out of range only when it is strictly below `thr_lo_i`.
- R3: With `pers_i == 0`, every valid result sets the interrupt status, whether it is in range or not.
- R4: With `pers_i == N` (1..15), the status sets on the N-th consecutive out-of-range valid result. An in-range valid result restarts the run. Cycles without `result_vld_i` neither advance nor restart it. The run count saturates at 15.
- R5: The status rises on the clock edge that samples the triggering strobe. It then stays set until a clear pulse. A clear pulse without a triggering strobe drops the status on the next edge and restarts the run count.
- R6: When a clear pulse and a valid result arrive in the same cycle, the run restarts and that result counts as the first of the new run. If that result triggers, the status is set rather than cleared.
- R7: `irq_n_o` is low exactly when the status is set and `irq_en_i` is high. `irq_en_i` has no effect on `irq_stat_o`.
- R8: `sat_evt_i` sets `sat_stat_o` on the next edge. The flag holds until a clear pulse. If an event and a clear arrive in the same cycle, the event wins.
- R9: `irq_gen_o` is high for exactly the one cycle in which the status newly rises. This includes a re-raise in the same cycle as a clear. A trigger while the status is already set gives no pulse.
- R10: After reset, `irq_stat_o`, `sat_stat_o` and `irq_gen_o` are low, `irq_n_o` is high, and the run count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | DATA_W | Proximity result |
| result_vld_i | input | 1 | One-cycle strobe for a new result |
| thr_lo_i | input | DATA_W | Low bound |
| thr_hi_i | input | DATA_W | High bound |
| pers_i | input | PERS_W | Persistence count; 0 means every cycle |
| irq_en_i | input | 1 | Gates the status onto the pin |
| sat_evt_i | input | 1 | Integrator saturation event |
| clr_i | input | 1 | Interrupt clear pulse |
| irq_stat_o | output | 1 | Latched interrupt status |
| irq_n_o | output | 1 | Interrupt pin, active low level |
| sat_stat_o | output | 1 | Latched saturation status |
| irq_gen_o | output | 1 | Pulse when the status newly rises |

## Verification
The properties assume that `result_vld_i`, `clr_i` and `sat_evt_i` are single-cycle pulses sampled on the rising edge. They also assume that the bounds and the persistence field stay steady while a strobe is sampled.

The stimulus drives every input on the falling edge. It changes the bounds, the persistence field and the enable only between strobes, so each sampled strobe sees a settled configuration.

The sweeps cover the equal-to-bound cases and crossed bounds. They run every persistence value, with runs broken by in-range results and stretched by idle cycles.

// File: rtl/prox_irq_pkg.sv
package prox_irq_pkg;
  typedef enum logic [1:0] {
    RNG_IN    = 2'd0,
    RNG_BELOW = 2'd1,
    RNG_ABOVE = 2'd2
  } rng_e;
endpackage

// File: rtl/prox_range_cmp.sv
module prox_range_cmp
  import prox_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output rng_e              cls_o
);
  // low bound is evaluated first; crossed bounds disable the high check
  always_comb begin
    if (value_i < lo_i)                        cls_o = RNG_BELOW;
    else if ((lo_i <= hi_i) && (value_i > hi_i)) cls_o = RNG_ABOVE;
    else                                       cls_o = RNG_IN;
  end
endmodule

// File: rtl/prox_persist_cnt.sv
module prox_persist_cnt #(
  parameter int PERS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              out_i,
  input  logic              clr_i,
  input  logic [PERS_W-1:0] pers_i,
  output logic              trig_o
);
  localparam logic [PERS_W-1:0] CNT_MAX = '1;

  logic [PERS_W-1:0] cnt_q, base, nxt;

  always_comb begin
    base   = clr_i ? '0 : cnt_q;
    nxt    = base;
    trig_o = 1'b0;
    if (vld_i) begin
      if (out_i) nxt = (base == CNT_MAX) ? base : base + 1'b1;
      else       nxt = '0;
      trig_o = (pers_i == '0) || (out_i && (nxt >= pers_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;
  end
endmodule

// File: rtl/prox_sticky_flag.sv
module prox_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/prox_irq_filter.sv
module prox_irq_filter
  import prox_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PERS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_vld_i,
  input  logic [DATA_W-1:0] thr_lo_i,
  input  logic [DATA_W-1:0] thr_hi_i,
  input  logic [PERS_W-1:0] pers_i,
  input  logic              irq_en_i,
  input  logic              sat_evt_i,
  input  logic              clr_i,
  output logic              irq_stat_o,
  output logic              irq_n_o,
  output logic              sat_stat_o,
  output logic              irq_gen_o
);
  rng_e cls;
  logic trig;
  logic gen_q;

  prox_range_cmp #(.DATA_W(DATA_W)) u_cmp (
    .value_i (result_i),
    .lo_i    (thr_lo_i),
    .hi_i    (thr_hi_i),
    .cls_o   (cls)
  );

  prox_persist_cnt #(.PERS_W(PERS_W)) u_pers (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (result_vld_i),
    .out_i  (cls != RNG_IN),
    .clr_i  (clr_i),
    .pers_i (pers_i),
    .trig_o (trig)
  );

  prox_sticky_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig),
    .clr_i  (clr_i),
    .q_o    (irq_stat_o)
  );

  prox_sticky_flag u_sat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sat_evt_i),
    .clr_i  (clr_i),
    .q_o    (sat_stat_o)
  );

  // pulse aligned with the rising status edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gen_q <= 1'b0;
    else         gen_q <= trig & (~irq_stat_o | clr_i);
  end

  assign irq_gen_o = gen_q;
  assign irq_n_o   = ~(irq_stat_o & irq_en_i);
endmodule

// File: rtl/prox_irq_filter_chk.sv
module prox_irq_filter_chk #(
  parameter int DATA_W = 16,
  parameter int PERS_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] result_i,
  input logic              result_vld_i,
  input logic [DATA_W-1:0] thr_lo_i,
  input logic [PERS_W-1:0] pers_i,
  input logic              irq_en_i,
  input logic              sat_evt_i,
  input logic              clr_i,
  input logic              irq_stat_o,
  input logic              irq_n_o,
  input logic              sat_stat_o,
  input logic              irq_gen_o
);
  p_below_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_i && pers_i == PERS_W'(1) && result_i < thr_lo_i) |=> irq_stat_o);

  p_every_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_i && pers_i == '0) |=> irq_stat_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_o && !clr_i) |=> irq_stat_o);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !result_vld_i) |=> !irq_stat_o);

  p_pin_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> irq_n_o);

  p_pin_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && irq_stat_o) |-> !irq_n_o);

  p_sat_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_evt_i |=> sat_stat_o);

  p_sat_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !sat_evt_i) |=> !sat_stat_o);

  p_gen_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_stat_o) |-> irq_gen_o);

  p_gen_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_gen_o |-> irq_stat_o);
endmodule

bind prox_irq_filter prox_irq_filter_chk #(.DATA_W(DATA_W), .PERS_W(PERS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .result_i     (result_i),
  .result_vld_i (result_vld_i),
  .thr_lo_i     (thr_lo_i),
  .pers_i       (pers_i),
  .irq_en_i     (irq_en_i),
  .sat_evt_i    (sat_evt_i),
  .clr_i        (clr_i),
  .irq_stat_o   (irq_stat_o),
  .irq_n_o      (irq_n_o),
  .sat_stat_o   (sat_stat_o),
  .irq_gen_o    (irq_gen_o)
);

// File: tb/tb_prox_irq_filter.sv
module tb_prox_irq_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] result_i = '0;
  logic        result_vld_i = 1'b0;
  logic [15:0] thr_lo_i = '0;
  logic [15:0] thr_hi_i = '0;
  logic [3:0]  pers_i = '0;
  logic        irq_en_i = 1'b0;
  logic        sat_evt_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        irq_stat_o, irq_n_o, sat_stat_o, irq_gen_o;

  int errors = 0;
  int checks = 0;

  // reference state
  int   m_cnt = 0;
  logic m_irq = 1'b0;
  logic m_sat = 1'b0;
  logic m_gen = 1'b0;

  always #10 clk_i = ~clk_i;

  prox_irq_filter dut (.*);

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string tag);
    logic [3:0] act, exp;
    act = {irq_stat_o, irq_gen_o, irq_n_o, sat_stat_o};
    exp = {m_irq, m_gen, ~(m_irq & irq_en_i), m_sat};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {irq,gen,pin_n,sat} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] r, input logic c,
                      input logic s, input string tag);
    logic out, trig;
    int   base, nc;
    @(negedge clk_i);
    result_vld_i = v; result_i = r; clr_i = c; sat_evt_i = s;
    out  = (r < thr_lo_i) || ((thr_lo_i <= thr_hi_i) && (r > thr_hi_i));
    base = c ? 0 : m_cnt;
    nc   = base;
    trig = 1'b0;
    if (v) begin
      nc   = out ? ((base == 15) ? 15 : base + 1) : 0;
      trig = (pers_i == 0) || (out && (nc >= int'(pers_i)));
    end
    @(posedge clk_i);
    m_gen = trig && (!m_irq || c);
    m_irq = trig ? 1'b1 : (c ? 1'b0 : m_irq);
    m_sat = s ? 1'b1 : (c ? 1'b0 : m_sat);
    m_cnt = nc;
    #1;
    check(tag);
    @(negedge clk_i);
    result_vld_i = 1'b0; clr_i = 1'b0; sat_evt_i = 1'b0;
  endtask

  logic [15:0] lo_set[4] = '{16'd0, 16'd100, 16'd200, 16'hFFFF};
  logic [15:0] hi_set[4] = '{16'd0, 16'd100, 16'd150, 16'hFFFF};
  logic [15:0] rs_set[10] = '{16'd0, 16'd99, 16'd100, 16'd101, 16'd150,
                              16'd151, 16'd199, 16'd200, 16'd201, 16'hFFFF};

  initial begin
    irq_en_i = 1'b1;
    #5;
    check("R10 reset");
    #30;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R10 after release");

    // R1 / R2: bound sweep with single-result persistence
    pers_i = 4'd1;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        thr_lo_i = lo_set[i]; thr_hi_i = hi_set[j];
        for (int k = 0; k < 10; k++) begin
          step(1'b0, 16'd0, 1'b1, 1'b0, "R5 clear");
          step(1'b1, rs_set[k], 1'b0, 1'b0,
               (lo_set[i] > hi_set[j]) ? "R2 crossed bounds" : "R1 range");
        end
      end
    end

    // R3 / R4: every persistence value, runs broken and stretched
    thr_lo_i = 16'd100; thr_hi_i = 16'd200;
    for (int p = 0; p < 16; p++) begin
      pers_i = 4'(p);
      step(1'b0, 16'd0, 1'b1, 1'b0, "R5 clear");
      for (int k = 0; k < p - 1; k++) step(1'b1, 16'd50, 1'b0, 1'b0, (p == 0) ? "R3" : "R4 run");
      step(1'b1, 16'd150, 1'b0, 1'b0, (p == 0) ? "R3 in range" : "R4 restart");
      for (int k = 0; k <= p; k++) begin
        step(1'b1, 16'd250, 1'b0, 1'b0, (p == 0) ? "R3" : "R4 run");
        if (k == 0) step(1'b0, 16'd250, 1'b0, 1'b0, "R4 idle gap");
      end
      step(1'b1, 16'd250, 1'b0, 1'b0, "R9 no re-pulse");
    end

    // R4: saturation of run count beyond 15
    pers_i = 4'd15;
    step(1'b0, 16'd0, 1'b1, 1'b0, "R5 clear");
    for (int k = 0; k < 20; k++) step(1'b1, 16'd10, 1'b0, 1'b0, "R4 long run");

    // R6: clear coinciding with a strobe
    pers_i = 4'd1;
    step(1'b1, 16'd10, 1'b1, 1'b0, "R6 clear with trigger");
    step(1'b1, 16'd150, 1'b1, 1'b0, "R6 clear with in-range");
    pers_i = 4'd2;
    step(1'b1, 16'd10, 1'b0, 1'b0, "R6 run");
    step(1'b1, 16'd10, 1'b1, 1'b0, "R6 clear restarts run");
    step(1'b1, 16'd10, 1'b0, 1'b0, "R6 second of new run");

    // R7: enable gates only the pin
    irq_en_i = 1'b0;
    #1 check("R7 pin masked");
    step(1'b0, 16'd0, 1'b0, 1'b0, "R7 status kept");
    irq_en_i = 1'b1;
    #1 check("R7 pin unmasked");
    step(1'b0, 16'd0, 1'b1, 1'b0, "R7 clear");

    // R8: saturation flag
    step(1'b0, 16'd0, 1'b0, 1'b1, "R8 set");
    step(1'b0, 16'd0, 1'b0, 1'b0, "R8 hold");
    step(1'b0, 16'd0, 1'b1, 1'b1, "R8 event beats clear");
    step(1'b0, 16'd0, 1'b1, 1'b0, "R8 clear");
    step(1'b0, 16'd0, 1'b0, 1'b0, "R8 stays clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule